// File: doc/BRIEF.md
# Dual-Select Byte-Lane SRAM Model

This block is a clocked, synthesizable model of the control side of an asynchronous 16-bit static RAM with two chip selects. One select is active low and the other is active high. An oversampling clock samples every control pin, the address and the incoming data. From those samples the block picks one of four modes: standby, output off, read or write. On a read it drives each of the two byte lanes separately. A write stores data only in the lanes that are enabled.

A write lasts as long as all of its qualifying inputs agree. The model keeps the data, the lane mask and the start address from the last sampled cycle of that overlap. It commits them to the array once it sees the overlap end, whichever input ended it. The array depth is a parameter, so a test can use a small array while the address port stays at its full 17 bits. A separate flag reports an address that moves while a write is in progress.

Top module: `sram_lane_model`

## Requirements
- R1: Standby (both bits of `dq_oe` at 0) follows any sampled cycle with `sel_n`=1, `sel`=0 or `lane_n`=2'b11.
- R2: When selected with `we_n`=1 and `oe_n`=1, neither lane is driven.
- R3: A read (selected, `we_n`=1, `oe_n`=0) sets `dq_oe[0]` when `lane_n[0]`=0 and `dq_oe[1]` when `lane_n[1]`=0. Bits 7:0 of `dq_o` carry the stored low byte and bits 15:8 carry the high byte. An undriven lane reads as zero on `dq_o`.
- R4: A write is any selected cycle with `we_n`=0. No lane is driven during it, and `oe_n` does not change what gets stored.
- R5: A write updates only the lanes whose `lane_n` bit is 0. The other byte of the word keeps its value.
- R6: The word stored is the `dq_i` value of the last sampled cycle inside the overlap. Raising `we_n`, raising `sel_n`, lowering `sel` or raising both lane enables all end the write the same way. Data that is present in the cycle that ends the write is not stored.
- R7: `addr_err` goes high one clock after any sampled overlap cycle, other than the first, whose address differs from the address at the start of the write. That write still lands at its start address. `addr_err` stays low for writes whose address does not move.
- R8: Only the low log2(DEPTH) address bits select a word, so addresses DEPTH apart reach the same word.
- R9: After reset, no lane is driven and `addr_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Active-low chip select |
| sel | input | 1 | Active-high chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| lane_n | input | 2 | Active-low byte enables, bit 0 low byte, bit 1 high byte |
| addr | input | 17 | Word address |
| dq_i | input | 16 | Data arriving from the bus |
| dq_o | output | 16 | Data driven onto the bus |
| dq_oe | output | 2 | Per-lane drive enable for `dq_o` |
| addr_err | output | 1 | Address moved during a write |

## Verification
A fault in the mode decode shows up on `dq_oe` one clock after the offending control pattern is sampled. A lost or stale lane mask, or a pending-data register that does not follow the overlap, leaves a wrong byte in the array. That byte appears on `dq_o` at the first read of the word, three clocks after the write ends. An address-tracking fault shows up either as a missing or spurious `addr_err` two clocks after the address moves, or as data found at the wrong word.

// File: rtl/sram_mdl_pkg.sv
package sram_mdl_pkg;

  typedef enum logic [1:0] {
    MD_STANDBY = 2'd0,
    MD_OUTOFF  = 2'd1,
    MD_READ    = 2'd2,
    MD_WRITE   = 2'd3
  } sram_mode_e;

  // Selection needs both chip selects active and at least one lane enabled.
  function automatic logic is_selected(logic sel_n, logic sel, logic any_lane);
    return !sel_n && sel && any_lane;
  endfunction

  // Mode priority: deselect first, then write, then output enable.
  function automatic sram_mode_e decode_mode(logic sel_n, logic sel, logic oe_n,
                                             logic we_n, logic any_lane);
    if (!is_selected(sel_n, sel, any_lane)) return MD_STANDBY;
    if (!we_n)                              return MD_WRITE;
    if (oe_n)                               return MD_OUTOFF;
    return MD_READ;
  endfunction

endpackage

// File: rtl/sram_in_sampler.sv
module sram_in_sampler #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic              s_sel_n,
  output logic              s_sel,
  output logic              s_oe_n,
  output logic              s_we_n,
  output logic [LANES-1:0]  s_lane_n,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DATA_W-1:0] s_dq
);

  // Reset values describe an idle, deselected bus.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_sel_n  <= 1'b1;
      s_sel    <= 1'b0;
      s_oe_n   <= 1'b1;
      s_we_n   <= 1'b1;
      s_lane_n <= '1;
      s_addr   <= '0;
      s_dq     <= '0;
    end else begin
      s_sel_n  <= sel_n;
      s_sel    <= sel;
      s_oe_n   <= oe_n;
      s_we_n   <= we_n;
      s_lane_n <= lane_n;
      s_addr   <= addr;
      s_dq     <= dq_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_mdl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_sel_n,
  input  logic              s_sel,
  input  logic              s_oe_n,
  input  logic              s_we_n,
  input  logic [LANES-1:0]  s_lane_n,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_dq,
  output sram_mode_e        mode,
  output logic              wr_act,
  output logic              end_evt,
  output logic [ADDR_W-1:0] cmt_addr,
  output logic [DATA_W-1:0] cmt_data,
  output logic [LANES-1:0]  cmt_mask,
  output logic [LANES-1:0]  lane_oe,
  output logic              addr_err
);

  logic wr_q;
  logic addr_moved;

  assign mode       = decode_mode(s_sel_n, s_sel, s_oe_n, s_we_n, !(&s_lane_n));
  assign wr_act     = (mode == MD_WRITE);
  assign end_evt    = wr_q && !wr_act;
  assign addr_moved = wr_act && wr_q && (s_addr != cmt_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_oe
    assign lane_oe[g] = (mode == MD_READ) && !s_lane_n[g];
  end

  // Pending write state follows the overlap; the address is held from its first cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      cmt_addr <= '0;
      cmt_data <= '0;
      cmt_mask <= '0;
      addr_err <= 1'b0;
    end else begin
      wr_q     <= wr_act;
      addr_err <= addr_moved;
      if (wr_act) begin
        if (!wr_q) cmt_addr <= s_addr;
        cmt_data <= s_dq;
        cmt_mask <= ~s_lane_n;
      end
    end
  end

endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int DATA_W = 16,
  parameter int LANES  = 2,
  parameter int DEPTH  = 2048,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LANE_W = DATA_W / LANES
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_mask,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask[l]) mem[wr_idx][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
  import sram_mdl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 2048,
  localparam int LANES  = DATA_W / 8,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [LANES-1:0]  dq_oe,
  output logic              addr_err
);

  logic              s_sel_n, s_sel, s_oe_n, s_we_n;
  logic [LANES-1:0]  s_lane_n;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_dq;
  sram_mode_e        mode;
  logic              wr_act, end_evt;
  logic [ADDR_W-1:0] cmt_addr;
  logic [DATA_W-1:0] cmt_data, rd_data;
  logic [LANES-1:0]  cmt_mask;

  sram_in_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_smp (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .we_n(we_n),
    .lane_n(lane_n), .addr(addr), .dq_i(dq_i),
    .s_sel_n(s_sel_n), .s_sel(s_sel), .s_oe_n(s_oe_n), .s_we_n(s_we_n),
    .s_lane_n(s_lane_n), .s_addr(s_addr), .s_dq(s_dq)
  );

  sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .s_sel_n(s_sel_n), .s_sel(s_sel), .s_oe_n(s_oe_n),
    .s_we_n(s_we_n), .s_lane_n(s_lane_n), .s_addr(s_addr), .s_dq(s_dq),
    .mode(mode), .wr_act(wr_act), .end_evt(end_evt), .cmt_addr(cmt_addr),
    .cmt_data(cmt_data), .cmt_mask(cmt_mask), .lane_oe(dq_oe), .addr_err(addr_err)
  );

  sram_array #(.DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH)) u_arr (
    .clk(clk), .wr_en(end_evt), .wr_idx(cmt_addr[IDX_W-1:0]), .wr_data(cmt_data),
    .wr_mask(cmt_mask), .rd_idx(s_addr[IDX_W-1:0]), .rd_data(rd_data)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_dq_out
    assign dq_o[g*8 +: 8] = dq_oe[g] ? rd_data[g*8 +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_lane_model_chk.sv
module sram_lane_model_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel_n,
  input logic             sel,
  input logic             oe_n,
  input logic             we_n,
  input logic [LANES-1:0] lane_n,
  input logic [LANES-1:0] dq_oe,
  input logic             addr_err,
  input logic             wr_act
);

  logic chosen;
  assign chosen = !sel_n && sel && !(&lane_n);

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chosen |=> (dq_oe == '0));  // R1

  AST_OUTOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (chosen && we_n && oe_n) |=> (dq_oe == '0));  // R2

  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (chosen && we_n && !oe_n) |=> (dq_oe == ~$past(lane_n)));  // R3

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |=> (dq_oe == '0));  // R4

  AST_ERR_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |-> $past(wr_act));  // R7

endmodule

bind sram_lane_model sram_lane_model_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .we_n(we_n),
  .lane_n(lane_n), .dq_oe(dq_oe), .addr_err(addr_err), .wr_act(wr_act)
);

// File: tb/tb_sram_lane_model.sv
`timescale 1ns/1ps
module tb_sram_lane_model;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int DEP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          sel_n = 1'b1, sel = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [1:0]    lane_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0;
  wire  [DW-1:0] dq_o;
  wire  [1:0]    dq_oe;
  wire           addr_err;

  int n_chk = 0;
  int n_bad = 0;
  logic [DW-1:0] model [DEP];

  sram_lane_model #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .we_n(we_n),
    .lane_n(lane_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
    .addr_err(addr_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drv(input logic sn, input logic s, input logic on, input logic wn,
                     input logic [1:0] ln, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sel_n = sn; sel = s; oe_n = on; we_n = wn; lane_n = ln; addr = a; dq_i = d;
  endtask

  task automatic go_idle();
    sel_n = 1'b1; sel = 1'b0; oe_n = 1'b1; we_n = 1'b1; lane_n = 2'b11;
  endtask

  // Two overlap cycles (junk then real data), then a chosen terminator with junk data.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic [1:0] ln, input int term);
    drv(1'b0, 1'b1, term[0], 1'b0, ln, a, ~d);
    wait_n(1);
    dq_i = d;
    wait_n(1);
    case (term)
      0: we_n = 1'b1;
      1: sel_n = 1'b1;
      2: sel = 1'b0;
      default: lane_n = 2'b11;
    endcase
    dq_i = 16'hDEAD;
    wait_n(1);
    go_idle();
    wait_n(2);
    check(addr_err == 1'b0, "R7 no error on steady write", 32'(addr_err), 32'd0);
    for (int l = 0; l < 2; l++)
      if (!ln[l]) model[a % DEP][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input logic [1:0] ln, input string req);
    logic [DW-1:0] exp;
    drv(1'b0, 1'b1, 1'b0, 1'b1, ln, a, dq_i);
    wait_n(1);
    exp = model[a % DEP];
    if (ln[0]) exp[7:0] = 8'h00;
    if (ln[1]) exp[15:8] = 8'h00;
    check(dq_oe == ~ln, {req, " lane enables"}, 32'(dq_oe), 32'(~ln));
    check(dq_o == exp, {req, " read data"}, 32'(dq_o), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    check(dq_oe == 2'b00, "R9 reset lanes", 32'(dq_oe), 32'd0);
    check(addr_err == 1'b0, "R9 reset error", 32'(addr_err), 32'd0);

    // R6: full words, every terminator in rotation, OE varied (R4)
    for (int a = 0; a < DEP; a++)
      wr(AW'(a), 16'(a * 16'h1111) ^ 16'h5A3C, 2'b00, a % 4);
    for (int a = 0; a < DEP; a++) rd_check(AW'(a), 2'b00, "R6");

    // R5: single-lane writes
    for (int a = 0; a < DEP; a++)
      wr(AW'(a), {8'(a + 8'h40), 8'(a + 8'hC0)}, (a % 2 == 1) ? 2'b01 : 2'b10, (a + 1) % 4);
    for (int a = 0; a < DEP; a++) rd_check(AW'(a), 2'b00, "R5");

    // R3: single-lane reads
    for (int a = 0; a < DEP; a += 3) begin
      rd_check(AW'(a), 2'b10, "R3 low lane");
      rd_check(AW'(a), 2'b01, "R3 high lane");
    end

    // R8: aliasing
    wr(AW'(DEP + 5), 16'hBEEF, 2'b00, 0);
    rd_check(AW'(5), 2'b00, "R8");
    rd_check(AW'(DEP * 3 + 5), 2'b00, "R8");

    // R1 R2 R3 R4: every control combination, writes carry the held value
    for (int c = 0; c < 64; c++) begin
      logic sn, s, on, wn;
      logic [1:0] ln, exp;
      string req;
      {sn, s, on, wn, ln} = 6'(c);
      if (sn || !s || (ln == 2'b11)) begin exp = 2'b00; req = "R1 deselect"; end
      else if (!wn) begin exp = 2'b00; req = "R4 write quiet"; end
      else if (on) begin exp = 2'b00; req = "R2 output off"; end
      else begin exp = ~ln; req = "R3 read lanes"; end
      drv(sn, s, on, wn, ln, AW'(7), model[7]);
      wait_n(1);
      check(dq_oe == exp, req, 32'(dq_oe), 32'(exp));
    end
    go_idle();
    wait_n(2);
    rd_check(AW'(7), 2'b00, "R4 word kept");

    // R7: address moves mid-write
    drv(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, AW'(9), 16'h1234);
    wait_n(2);
    check(addr_err == 1'b0, "R7 before move", 32'(addr_err), 32'd0);
    addr = AW'(10);
    wait_n(2);
    check(addr_err == 1'b1, "R7 flagged", 32'(addr_err), 32'd1);
    we_n = 1'b1;
    wait_n(1);
    go_idle();
    wait_n(3);
    check(addr_err == 1'b0, "R7 cleared", 32'(addr_err), 32'd0);
    model[9] = 16'h1234;
    rd_check(AW'(9), 2'b00, "R7 start address");
    rd_check(AW'(10), 2'b00, "R7 other word");

    go_idle();
    wait_n(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule